// File: doc/BRIEF.md
# Linked Control-Block DMA Channel

This block is one DMA channel that executes a chain of transfer descriptors kept in memory. A descriptor occupies 32 bytes. Its first six words are fetched in this order: control word, source address, destination address, byte length, stride, next-descriptor address. The remaining two words are never read. After a start pulse the channel fetches the descriptor at the supplied head address and copies the requested number of 32-bit words through separate read and write ports. It then follows the next pointer. A next pointer of zero ends the chain and the channel goes idle. A pointer back to an earlier descriptor makes the chain run forever, until reset.

Bits of the control word set each descriptor's behaviour:

| Bits | Function |
|------|----------|
| 0 | interrupt when the block completes |
| 3 | wait for the write response after each write |
| 4 | increment the destination address |
| 6 | pace writes by a peripheral request line |
| 7 | skip writes |
| 8 | increment the source address |
| 10 | pace reads by a peripheral request line |
| 11 | skip reads and supply zero data |
| 20:16 | peripheral request line number |
| 25:21 | idle cycles inserted before each word |

A build parameter selects a reduced-length variant of the channel. The current descriptor, source and destination addresses are visible on outputs, so that software can work out how much of a transfer is left.

Top module: `cbdma_channel`

## Requirements
- R1: After reset `busy_o`, `irq_o`, `cb_req_o`, `rd_req_o` and `wr_req_o` are 0, and `cur_cb_o` reads 0.
- R2: A `go_i` pulse while idle starts fetching at `head_i` with bits 4:0 cleared. Six word reads go to that base plus 0, 4, 8, 12, 16 and 20. A head whose bits 31:5 are all zero is ignored.
- R3: The channel moves ceil(L/4) whole words, where L is the byte length after the limit of R12. A length of 0 moves nothing. Each read and write request stays high until it is acknowledged.
- R4: When control bit 8 is set, the source address advances by 4 after each word, and when it is clear the source address stays fixed. Control bit 4 does the same for the destination address.
- R5: When a block ends, a nonzero next pointer, with bits 4:0 cleared, is fetched as the following block. When the next pointer is zero, `busy_o` falls and `cur_cb_o` reads 0.
- R6: When control bit 0 is set, `irq_o` goes high for exactly one cycle after the block's last word. When it is clear, the block raises no interrupt.
- R7: When control bit 11 is set, the block issues no read requests and writes zero data.
- R8: When control bit 7 is set, the block issues no write requests, but its reads still take place.
- R9: When control bit 10 is set, a read is issued only after `dreq_i[n]` is high, where n is control bits 20:16. Control bit 6 applies the same rule to writes.
- R10: When control bit 3 is set, the next word does not start until `wr_resp_i` has pulsed for the previous write.
- R11: A nonzero value W in control bits 25:21 adds exactly W idle cycles before each word.
- R12: With `LITE_CHAN`=1 the byte length is clamped to `LITE_MAX_BYTES`. Otherwise it is clamped to `FULL_MAX_BYTES`.
- R13: A `go_i` pulse while busy is ignored. `cur_src_o` and `cur_dst_o` show the address of the next word still to be moved.
- R14: A chain whose last next pointer refers back to its first block repeats without end and raises an interrupt on every enabled block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst_n | input | 1 | active-low asynchronous reset |
| go_i | input | 1 | start pulse |
| head_i | input | 32 | first descriptor address |
| busy_o | output | 1 | chain in progress |
| cur_cb_o | output | 32 | current descriptor address, 0 when idle |
| cur_src_o | output | 32 | next source address |
| cur_dst_o | output | 32 | next destination address |
| irq_o | output | 1 | block-complete interrupt pulse |
| cb_req_o | output | 1 | descriptor read request |
| cb_addr_o | output | 32 | descriptor read address |
| cb_ack_i | input | 1 | descriptor read acknowledge with data |
| cb_rdata_i | input | 32 | descriptor read data |
| rd_req_o | output | 1 | data read request |
| rd_addr_o | output | 32 | data read address |
| rd_ack_i | input | 1 | data read acknowledge with data |
| rd_data_i | input | 32 | data read data |
| wr_req_o | output | 1 | data write request |
| wr_addr_o | output | 32 | data write address |
| wr_data_o | output | 32 | data write data |
| wr_ack_i | input | 1 | write accepted |
| wr_resp_i | input | 1 | write response pulse |
| dreq_i | input | 32 | peripheral request lines |

## Verification
Every request reaches the memory ports one register after the state that produces it. The interrupt and the fall of `busy_o` come one cycle after the last word's handshake. The bench's memory model therefore answers each request on the next clock edge, and all results are read on the falling edge after the bench has waited for `busy_o` to drop. The bench checks stalled states (pacing and held write responses) after a fixed wait of 30 cycles, which is longer than any legal path to the next request. The R11 check compares the total run time with and without inserted idle cycles, because that difference must be exactly W cycles per word whatever the memory latency.

// File: rtl/cbdma_pkg.sv
package cbdma_pkg;
    localparam int WORD_W    = 32;
    localparam int CB_FETCH  = 6;
    localparam int SEL_W     = 5;
    localparam int GAP_W     = 5;
    localparam int NREQ      = 1 << SEL_W;
    localparam int CB_ALIGN  = 5;

    typedef struct packed {
        logic [GAP_W-1:0] gap;
        logic [SEL_W-1:0] sel;
        logic             src_zero;
        logic             src_pace;
        logic             src_inc;
        logic             dst_skip;
        logic             dst_pace;
        logic             dst_inc;
        logic             hold_resp;
        logic             irq_en;
    } ctl_t;

    function automatic ctl_t decode_ctl(input logic [WORD_W-1:0] w);
        ctl_t c;
        c.irq_en    = w[0];
        c.hold_resp = w[3];
        c.dst_inc   = w[4];
        c.dst_pace  = w[6];
        c.dst_skip  = w[7];
        c.src_inc   = w[8];
        c.src_pace  = w[10];
        c.src_zero  = w[11];
        c.sel       = w[20:16];
        c.gap       = w[25:21];
        return c;
    endfunction

    typedef enum logic [1:0] {SEQ_IDLE, SEQ_FETCH, SEQ_MOVE} seq_e;
    typedef enum logic [2:0] {MV_IDLE, MV_GAP, MV_READ, MV_WRITE, MV_RESP} mv_e;
endpackage

// File: rtl/cbdma_fetch.sv
module cbdma_fetch
    import cbdma_pkg::*;
#(
    parameter int NWORDS = CB_FETCH,
    parameter int AW     = WORD_W,
    parameter int DW     = WORD_W
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [AW-1:0]              base_i,
    output logic                       cb_req_o,
    output logic [AW-1:0]              cb_addr_o,
    input  logic                       cb_ack_i,
    input  logic [DW-1:0]              cb_rdata_i,
    output logic                       done_o,
    output logic [NWORDS-1:0][DW-1:0]  words_o
);
    localparam int IDX_W = $clog2(NWORDS);

    typedef struct packed {
        logic                      busy;
        logic [IDX_W-1:0]          idx;
        logic [AW-1:0]             base;
        logic [NWORDS-1:0][DW-1:0] words;
        logic                      done;
    } fst_t;

    fst_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (!st_q.busy) begin
            if (start_i) begin
                st_d.busy = 1'b1;
                st_d.idx  = '0;
                st_d.base = base_i;
            end
        end else if (cb_ack_i) begin
            st_d.words[st_q.idx] = cb_rdata_i;
            if (st_q.idx == IDX_W'(NWORDS - 1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.idx = st_q.idx + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cb_req_o  = st_q.busy;
    assign cb_addr_o = st_q.base + AW'({st_q.idx, 2'b00});
    assign done_o    = st_q.done;
    assign words_o   = st_q.words;

    AST_CB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        cb_req_o && !cb_ack_i |=> cb_req_o && $stable(cb_addr_o)); // R2
    AST_CB_WITHIN: assert property (@(posedge clk) disable iff (!rst_n)
        cb_req_o |-> cb_addr_o[CB_ALIGN-1:0] < CB_ALIGN'(4 * NWORDS)); // R2
endmodule

// File: rtl/cbdma_mover.sv
module cbdma_mover
    import cbdma_pkg::*;
#(
    parameter int AW    = WORD_W,
    parameter int DW    = WORD_W,
    parameter int CNT_W = 29
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  ctl_t              ctl_i,
    input  logic [AW-1:0]     src_i,
    input  logic [AW-1:0]     dst_i,
    input  logic [CNT_W-1:0]  nwords_i,
    output logic              rd_req_o,
    output logic [AW-1:0]     rd_addr_o,
    input  logic              rd_ack_i,
    input  logic [DW-1:0]     rd_data_i,
    output logic              wr_req_o,
    output logic [AW-1:0]     wr_addr_o,
    output logic [DW-1:0]     wr_data_o,
    input  logic              wr_ack_i,
    input  logic              wr_resp_i,
    input  logic [NREQ-1:0]   dreq_i,
    output logic [AW-1:0]     src_o,
    output logic [AW-1:0]     dst_o,
    output logic              done_o
);
    localparam logic [AW-1:0] STEP = AW'(DW / 8);

    typedef struct packed {
        mv_e              st;
        ctl_t             ctl;
        logic [AW-1:0]    src;
        logic [AW-1:0]    dst;
        logic [CNT_W-1:0] left;
        logic [GAP_W-1:0] gap_cnt;
        logic [DW-1:0]    data;
        logic             rd_req;
        logic             wr_req;
        logic             done;
    } mst_t;

    mst_t mv_d, mv_q;
    logic pace_ok;
    logic word_fin;

    always_comb begin
        mv_d      = mv_q;
        mv_d.done = 1'b0;
        word_fin  = 1'b0;
        pace_ok   = dreq_i[mv_q.ctl.sel];
        case (mv_q.st)
            MV_IDLE: begin
                if (start_i) begin
                    mv_d.ctl     = ctl_i;
                    mv_d.src     = src_i;
                    mv_d.dst     = dst_i;
                    mv_d.left    = nwords_i;
                    mv_d.gap_cnt = ctl_i.gap;
                    if (nwords_i == '0)     mv_d.done = 1'b1;
                    else if (ctl_i.gap != 0) mv_d.st  = MV_GAP;
                    else                     mv_d.st  = MV_READ;
                end
            end
            MV_GAP: begin
                mv_d.gap_cnt = mv_q.gap_cnt - 1'b1;
                if (mv_q.gap_cnt <= GAP_W'(1)) mv_d.st = MV_READ;
            end
            MV_READ: begin
                if (mv_q.ctl.src_zero) begin
                    mv_d.data = '0;
                    mv_d.st   = MV_WRITE;
                end else if (!mv_q.rd_req) begin
                    if (!mv_q.ctl.src_pace || pace_ok) mv_d.rd_req = 1'b1;
                end else if (rd_ack_i) begin
                    mv_d.rd_req = 1'b0;
                    mv_d.data   = rd_data_i;
                    mv_d.st     = MV_WRITE;
                end
            end
            MV_WRITE: begin
                if (mv_q.ctl.dst_skip) begin
                    word_fin = 1'b1;
                end else if (!mv_q.wr_req) begin
                    if (!mv_q.ctl.dst_pace || pace_ok) mv_d.wr_req = 1'b1;
                end else if (wr_ack_i) begin
                    mv_d.wr_req = 1'b0;
                    if (mv_q.ctl.hold_resp) mv_d.st = MV_RESP;
                    else                    word_fin = 1'b1;
                end
            end
            MV_RESP: begin
                if (wr_resp_i) word_fin = 1'b1;
            end
            default: mv_d.st = MV_IDLE;
        endcase

        if (word_fin) begin
            if (mv_q.ctl.src_inc) mv_d.src = mv_q.src + STEP;
            if (mv_q.ctl.dst_inc) mv_d.dst = mv_q.dst + STEP;
            mv_d.left = mv_q.left - 1'b1;
            if (mv_q.left == CNT_W'(1)) begin
                mv_d.done = 1'b1;
                mv_d.st   = MV_IDLE;
            end else begin
                mv_d.gap_cnt = mv_q.ctl.gap;
                mv_d.st      = (mv_q.ctl.gap != 0) ? MV_GAP : MV_READ;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) mv_q <= '0;
        else        mv_q <= mv_d;
    end

    assign rd_req_o  = mv_q.rd_req;
    assign rd_addr_o = mv_q.src;
    assign wr_req_o  = mv_q.wr_req;
    assign wr_addr_o = mv_q.dst;
    assign wr_data_o = mv_q.data;
    assign src_o     = mv_q.src;
    assign dst_o     = mv_q.dst;
    assign done_o    = mv_q.done;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o && !rd_ack_i |=> rd_req_o && $stable(rd_addr_o)); // R3
    AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o && !wr_ack_i |=> wr_req_o && $stable(wr_addr_o) && $stable(wr_data_o)); // R3
    AST_NO_ZERO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_o |-> !mv_q.ctl.src_zero); // R7
    AST_NO_SKIP_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req_o |-> !mv_q.ctl.dst_skip); // R8
    AST_PACED_READ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rd_req_o) && mv_q.ctl.src_pace |-> $past(dreq_i[mv_q.ctl.sel])); // R9
    AST_RESP_GATE: assert property (@(posedge clk) disable iff (!rst_n)
        mv_q.st == MV_RESP && !wr_resp_i |=> !rd_req_o && !wr_req_o); // R10
endmodule

// File: rtl/cbdma_channel.sv
module cbdma_channel
    import cbdma_pkg::*;
#(
    parameter bit LITE_CHAN      = 1'b0,
    parameter int LITE_MAX_BYTES = 65532,
    parameter int FULL_MAX_BYTES = 1 << 30
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 go_i,
    input  logic [WORD_W-1:0]    head_i,
    output logic                 busy_o,
    output logic [WORD_W-1:0]    cur_cb_o,
    output logic [WORD_W-1:0]    cur_src_o,
    output logic [WORD_W-1:0]    cur_dst_o,
    output logic                 irq_o,
    output logic                 cb_req_o,
    output logic [WORD_W-1:0]    cb_addr_o,
    input  logic                 cb_ack_i,
    input  logic [WORD_W-1:0]    cb_rdata_i,
    output logic                 rd_req_o,
    output logic [WORD_W-1:0]    rd_addr_o,
    input  logic                 rd_ack_i,
    input  logic [WORD_W-1:0]    rd_data_i,
    output logic                 wr_req_o,
    output logic [WORD_W-1:0]    wr_addr_o,
    output logic [WORD_W-1:0]    wr_data_o,
    input  logic                 wr_ack_i,
    input  logic                 wr_resp_i,
    input  logic [NREQ-1:0]      dreq_i
);
    localparam int MAX_BYTES = LITE_CHAN ? LITE_MAX_BYTES : FULL_MAX_BYTES;
    localparam int CNT_W     = $clog2(MAX_BYTES / 4 + 1);
    localparam int W_INFO = 0, W_SRC = 1, W_DST = 2, W_LEN = 3, W_NEXT = 5;

    typedef struct packed {
        seq_e              seq;
        logic [WORD_W-1:0] cb;
        logic [WORD_W-1:0] next;
        logic              irq_en;
        logic              irq;
    } tst_t;

    tst_t sq_d, sq_q;

    logic                            f_go, f_done, m_go, m_done;
    logic [WORD_W-1:0]               f_base;
    logic [CB_FETCH-1:0][WORD_W-1:0] f_words;
    ctl_t                            blk_ctl;
    logic [WORD_W-1:0]               len_eff;
    logic [WORD_W:0]                 len_rnd;
    logic [CNT_W-1:0]                blk_words;

    always_comb begin
        blk_ctl   = decode_ctl(f_words[W_INFO]);
        len_eff   = (f_words[W_LEN] > WORD_W'(MAX_BYTES)) ? WORD_W'(MAX_BYTES) : f_words[W_LEN];
        len_rnd   = {1'b0, len_eff} + (WORD_W+1)'(3);
        blk_words = len_rnd[CNT_W+1:2];
    end

    always_comb begin
        sq_d     = sq_q;
        sq_d.irq = 1'b0;
        f_go     = 1'b0;
        f_base   = '0;
        m_go     = 1'b0;
        case (sq_q.seq)
            SEQ_IDLE: begin
                if (go_i && head_i[WORD_W-1:CB_ALIGN] != '0) begin
                    f_go     = 1'b1;
                    f_base   = {head_i[WORD_W-1:CB_ALIGN], {CB_ALIGN{1'b0}}};
                    sq_d.cb  = f_base;
                    sq_d.seq = SEQ_FETCH;
                end
            end
            SEQ_FETCH: begin
                if (f_done) begin
                    m_go        = 1'b1;
                    sq_d.next   = {f_words[W_NEXT][WORD_W-1:CB_ALIGN], {CB_ALIGN{1'b0}}};
                    sq_d.irq_en = blk_ctl.irq_en;
                    sq_d.seq    = SEQ_MOVE;
                end
            end
            SEQ_MOVE: begin
                if (m_done) begin
                    sq_d.irq = sq_q.irq_en;
                    if (sq_q.next == '0) begin
                        sq_d.cb  = '0;
                        sq_d.seq = SEQ_IDLE;
                    end else begin
                        f_go     = 1'b1;
                        f_base   = sq_q.next;
                        sq_d.cb  = sq_q.next;
                        sq_d.seq = SEQ_FETCH;
                    end
                end
            end
            default: sq_d.seq = SEQ_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sq_q <= '0;
        else        sq_q <= sq_d;
    end

    cbdma_fetch #(.NWORDS(CB_FETCH), .AW(WORD_W), .DW(WORD_W)) u_fetch (
        .clk        (clk),
        .rst_n      (rst_n),
        .start_i    (f_go),
        .base_i     (f_base),
        .cb_req_o   (cb_req_o),
        .cb_addr_o  (cb_addr_o),
        .cb_ack_i   (cb_ack_i),
        .cb_rdata_i (cb_rdata_i),
        .done_o     (f_done),
        .words_o    (f_words)
    );

    cbdma_mover #(.AW(WORD_W), .DW(WORD_W), .CNT_W(CNT_W)) u_mover (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_i   (m_go),
        .ctl_i     (blk_ctl),
        .src_i     (f_words[W_SRC]),
        .dst_i     (f_words[W_DST]),
        .nwords_i  (blk_words),
        .rd_req_o  (rd_req_o),
        .rd_addr_o (rd_addr_o),
        .rd_ack_i  (rd_ack_i),
        .rd_data_i (rd_data_i),
        .wr_req_o  (wr_req_o),
        .wr_addr_o (wr_addr_o),
        .wr_data_o (wr_data_o),
        .wr_ack_i  (wr_ack_i),
        .wr_resp_i (wr_resp_i),
        .dreq_i    (dreq_i),
        .src_o     (cur_src_o),
        .dst_o     (cur_dst_o),
        .done_o    (m_done)
    );

    assign busy_o   = (sq_q.seq != SEQ_IDLE);
    assign cur_cb_o = sq_q.cb;
    assign irq_o    = sq_q.irq;

    AST_IDLE_CB_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_o |-> cur_cb_o == '0); // R5
    AST_IRQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o); // R6
    AST_NO_FETCH_IN_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        sq_q.seq == SEQ_MOVE |-> !cb_req_o); // R5
endmodule

// File: tb/test_cbdma_channel.sv
module test_cbdma_channel;
    import cbdma_pkg::*;

    localparam int LITE_BYTES = 16;
    localparam int WD_CYCLES  = 150000;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic go, busy, irq, cb_req, cb_ack, rd_req, rd_ack, wr_req, wr_ack, wr_resp;
    logic [31:0] head, cur_cb, cur_src, cur_dst, cb_addr, cb_rdata, rd_addr, rd_data;
    logic [31:0] wr_addr, wr_data, dreq;

    cbdma_channel #(.LITE_CHAN(1'b1), .LITE_MAX_BYTES(LITE_BYTES)) i_cbdma_channel (
        .clk(clk), .rst_n(rst_n), .go_i(go), .head_i(head), .busy_o(busy),
        .cur_cb_o(cur_cb), .cur_src_o(cur_src), .cur_dst_o(cur_dst), .irq_o(irq),
        .cb_req_o(cb_req), .cb_addr_o(cb_addr), .cb_ack_i(cb_ack), .cb_rdata_i(cb_rdata),
        .rd_req_o(rd_req), .rd_addr_o(rd_addr), .rd_ack_i(rd_ack), .rd_data_i(rd_data),
        .wr_req_o(wr_req), .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_ack_i(wr_ack),
        .wr_resp_i(wr_resp), .dreq_i(dreq)
    );

    // memory model: one-cycle acknowledge, write response one cycle after accept
    logic [31:0] mem [0:255];
    int rd_cnt, wr_cnt, irq_cnt, cb_cnt;
    logic seen140, resp_hold, resp_pend, clr, hw_en;
    logic [31:0] first_cb, hw_addr, hw_data;

    always @(posedge clk) begin
        cb_ack  <= 1'b0;
        rd_ack  <= 1'b0;
        wr_ack  <= 1'b0;
        wr_resp <= 1'b0;
        if (hw_en) mem[hw_addr[9:2]] <= hw_data;
        if (resp_pend && !resp_hold) begin
            wr_resp   <= 1'b1;
            resp_pend <= 1'b0;
        end
        if (clr) begin
            rd_cnt <= 0; wr_cnt <= 0; irq_cnt <= 0; cb_cnt <= 0; seen140 <= 1'b0;
        end else begin
            if (cb_req && !cb_ack) begin
                cb_ack   <= 1'b1;
                cb_rdata <= mem[cb_addr[9:2]];
                if (cb_cnt == 0) first_cb <= cb_addr;
                if (cb_addr == 32'h140) seen140 <= 1'b1;
                cb_cnt <= cb_cnt + 1;
            end
            if (rd_req && !rd_ack) begin
                rd_ack  <= 1'b1;
                rd_data <= mem[rd_addr[9:2]];
                rd_cnt  <= rd_cnt + 1;
            end
            if (wr_req && !wr_ack) begin
                wr_ack <= 1'b1;
                mem[wr_addr[9:2]] <= wr_data;
                wr_cnt    <= wr_cnt + 1;
                resp_pend <= 1'b1;
            end
            if (irq) irq_cnt <= irq_cnt + 1;
        end
    end

    int n_tests = 0;
    int n_fail  = 0;

    task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic poke(input logic [31:0] a, input logic [31:0] d);
        @(negedge clk);
        hw_en = 1'b1; hw_addr = a; hw_data = d;
        @(negedge clk);
        hw_en = 1'b0;
    endtask

    task automatic put_cb(input logic [31:0] b, input logic [31:0] info, input logic [31:0] s,
                          input logic [31:0] d, input logic [31:0] len, input logic [31:0] nxt);
        poke(b, info); poke(b + 4, s); poke(b + 8, d);
        poke(b + 12, len); poke(b + 16, 32'h0); poke(b + 20, nxt);
    endtask

    function automatic logic [31:0] src_pat(input int i);
        return 32'hA500_0000 + i;
    endfunction

    task automatic fill();
        for (int i = 0; i < 16; i++) begin
            poke(32'h200 + 4 * i, src_pat(i));
            poke(32'h300 + 4 * i, 32'hDEAD_BEEF);
            poke(32'h380 + 4 * i, 32'hDEAD_BEEF);
        end
    endtask

    task automatic start(input logic [31:0] h);
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0; go = 1'b1; head = h;
        @(negedge clk);
        go = 1'b0;
    endtask

    task automatic wait_idle(output int cyc);
        cyc = 2;
        while (busy && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        @(negedge clk);
    endtask

    typedef struct packed {
        logic [7:0]  tag;
        logic [31:0] info;
        logic [31:0] len;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{8'd3,  32'h0000_0110, 32'd8},   // R3 both increment
        '{8'd3,  32'h0000_0110, 32'd10},  // R3 rounds up to 3 words
        '{8'd3,  32'h0000_0110, 32'd0},   // R3 empty block
        '{8'd4,  32'h0000_0100, 32'd12},  // R4 fixed destination
        '{8'd7,  32'h0000_0810, 32'd8},   // R7 zero source
        '{8'd8,  32'h0000_0180, 32'd8},   // R8 writes skipped
        '{8'd6,  32'h0000_0111, 32'd4},   // R6 interrupt enabled
        '{8'd12, 32'h0000_0110, 32'd40}   // R12 clamped to 16 bytes
    };

    initial begin
        repeat (WD_CYCLES) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int cyc, c0, c3, w, e, g;
        logic [31:0] exp0;
        string tg;
        go = 0; head = 0; dreq = 0; clr = 0; hw_en = 0; hw_addr = 0; hw_data = 0;
        resp_hold = 0; resp_pend = 0;
        rd_cnt = 0; wr_cnt = 0; irq_cnt = 0; cb_cnt = 0; seen140 = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "busy", 32'(busy), 0);
        chk("R1", "cur_cb", cur_cb, 0);
        chk("R1", "requests", {29'd0, cb_req, rd_req, wr_req}, 0);
        chk("R1", "irq", 32'(irq), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // table of single-block vectors
        foreach (VECS[k]) begin
            tg = $sformatf("R%0d", VECS[k].tag);
            fill();
            put_cb(32'h100, VECS[k].info, 32'h200, 32'h300, VECS[k].len, 32'h0);
            start(32'h100);
            wait_idle(cyc);
            e = (VECS[k].len > LITE_BYTES) ? LITE_BYTES : int'(VECS[k].len);
            w = (e + 3) / 4;
            chk(tg, "reads", rd_cnt, VECS[k].info[11] ? 0 : w);
            chk(tg, "writes", wr_cnt, VECS[k].info[7] ? 0 : w);
            chk(tg, "irqs", irq_cnt, 32'(VECS[k].info[0]));
            if (VECS[k].info[7] || w == 0)  exp0 = 32'hDEAD_BEEF;
            else if (VECS[k].info[11])      exp0 = 32'h0;
            else if (VECS[k].info[4])       exp0 = src_pat(0);
            else                            exp0 = src_pat(VECS[k].info[8] ? w - 1 : 0);
            chk(tg, "first dst word", mem[8'hC0], exp0);
            if (VECS[k].info[4] && !VECS[k].info[7])
                chk(tg, "word past end", mem[8'hC0 + w], 32'hDEAD_BEEF);
            chk("R5", "cb after end", cur_cb, 0);
        end

        // R2 low head bits cleared, six fetches
        fill();
        put_cb(32'h100, 32'h110, 32'h200, 32'h300, 32'd4, 32'h0);
        start(32'h10F);
        wait_idle(cyc);
        chk("R2", "first fetch addr", first_cb, 32'h100);
        chk("R2", "fetch count", cb_cnt, 6);
        // R2 zero head ignored
        start(32'h1F);
        repeat (5) @(negedge clk);
        chk("R2", "zero head busy", 32'(busy), 0);
        chk("R2", "zero head fetches", cb_cnt, 0);

        // R5 two-block chain
        fill();
        put_cb(32'h100, 32'h111, 32'h200, 32'h300, 32'd8, 32'h140);
        put_cb(32'h140, 32'h111, 32'h210, 32'h380, 32'd4, 32'h0);
        start(32'h100);
        wait_idle(cyc);
        chk("R5", "second block fetched", 32'(seen140), 1);
        chk("R5", "fetch count", cb_cnt, 12);
        chk("R5", "second block data", mem[8'hE0], src_pat(4));
        chk("R6", "irq per block", irq_cnt, 2);
        chk("R5", "idle cb", cur_cb, 0);

        // R9 source pacing on line 5, R13 address visible while stalled
        fill();
        put_cb(32'h100, 32'h0005_0510, 32'h200, 32'h300, 32'd8, 32'h0);
        dreq = 0;
        start(32'h100);
        repeat (30) @(negedge clk);
        chk("R9", "reads while unpaced", rd_cnt, 0);
        chk("R13", "src while stalled", cur_src, 32'h200);
        dreq[5] = 1'b1;
        wait_idle(cyc);
        chk("R9", "writes after pace", wr_cnt, 2);
        chk("R13", "src after run", cur_src, 32'h208);
        chk("R13", "dst after run", cur_dst, 32'h308);
        dreq = 0;

        // R9 destination pacing on line 3, R13 go while busy
        fill();
        put_cb(32'h100, 32'h0003_0150, 32'h200, 32'h300, 32'd8, 32'h0);
        put_cb(32'h140, 32'h110, 32'h200, 32'h380, 32'd4, 32'h0);
        start(32'h100);
        repeat (30) @(negedge clk);
        chk("R9", "reads before write pace", rd_cnt, 1);
        chk("R9", "writes while unpaced", wr_cnt, 0);
        go = 1'b1; head = 32'h140;
        @(negedge clk);
        go = 1'b0;
        dreq[3] = 1'b1;
        wait_idle(cyc);
        chk("R9", "writes after pace", wr_cnt, 2);
        chk("R13", "ignored go fetches", cb_cnt, 6);
        chk("R13", "ignored go block", 32'(seen140), 0);
        dreq = 0;

        // R10 write response gating
        fill();
        put_cb(32'h100, 32'h118, 32'h200, 32'h300, 32'd8, 32'h0);
        resp_hold = 1'b1;
        start(32'h100);
        repeat (30) @(negedge clk);
        chk("R10", "writes while resp held", wr_cnt, 1);
        resp_hold = 1'b0;
        wait_idle(cyc);
        chk("R10", "writes after resp", wr_cnt, 2);

        // R11 inserted idle cycles
        fill();
        put_cb(32'h100, 32'h110, 32'h200, 32'h300, 32'd8, 32'h0);
        start(32'h100);
        wait_idle(c0);
        put_cb(32'h100, 32'h0060_0110, 32'h200, 32'h300, 32'd8, 32'h0);
        start(32'h100);
        wait_idle(c3);
        chk("R11", "extra cycles for 2 words, W=3", 32'(c3 - c0), 6);

        // R14 self-linked chain loops until reset
        fill();
        put_cb(32'h100, 32'h111, 32'h200, 32'h300, 32'd4, 32'h100);
        start(32'h100);
        g = 0;
        while (irq_cnt < 3 && g < 2000) begin
            @(negedge clk);
            g++;
        end
        chk("R14", "loop irqs", 32'(irq_cnt >= 3), 1);
        chk("R14", "still busy", 32'(busy), 1);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        chk("R1", "busy in reset", 32'(busy), 0);
        chk("R1", "cb in reset", cur_cb, 0);
        chk("R1", "requests in reset", {29'd0, cb_req, rd_req, wr_req}, 0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule